// File: doc/BRIEF.md
# Colour Channel and Gain/Offset Rotation Sequencer

This block decides, for a three-colour linear image sensor front end, which colour (red, green or blue) drives the input multiplexer. It also decides which colour's gain and offset settings feed the amplifier and offset converter. A 2-bit configuration picks one of four behaviours:

- red only;
- red input with the gain/offset selection rotating per pixel;
- all three inputs rotating per pixel;
- all three inputs rotating once per line.

In the per-pixel triple case the block also pulses a strobe when all three colours are sampled at once. That pulse comes on every third converter cycle, at the cycle in which red is converted.

The block runs on a fast system clock. It samples the converter clock, the line-start pulse and the clamp pulse as synchronous inputs, and it acts on the converter clock's falling edge and on the line pulse's rising edge. Each colour's gain and offset arrive as packed tables. The block registers the selected entries and changes them only at a colour boundary. A user of the block can reset the line rotation to red with a one-cycle command pulse.

Top module: `chroma_rotator`

## Requirements
- R1: After reset the channel select is 0 (red), the gain and offset outputs are 0, and the sample strobe and all tracking enables are 0.
- R2: With configuration 00 the channel select is red (0) and the gain/offset outputs carry table entry 0 at every pixel.
- R3: With configuration 01 the channel select stays red (0), while the gain/offset selection steps red(0)→green(1)→blue(2)→red on each falling converter clock edge.
- R4: With configuration 10 the channel select and the gain/offset selection step together red→green→blue→red on each falling converter clock edge.
- R5: While the line pulse is high the pixel pointer is held at red. The first falling converter edge after the line pulse drops keeps red, and later edges advance. Every output update occurs one system clock after the input edge that causes it.
- R6: With configuration 10 the sample strobe is high for exactly one system clock after each falling converter edge that selects red, which is every third edge.
- R7: With configuration 11 the colour advances at each rising edge of the line pulse and wraps from blue to red. The first line start after reset or after a reset-to-red command stays red.
- R8: A reset-to-red command forces the line colour to red and reloads the red gain and offset.
- R9: The gain and offset outputs change only at a colour boundary (a falling converter edge outside the line pulse, a line start, or a reset-to-red command). With configuration 11 they reload only at a line start or a command, so a table change in the middle of a line has no effect until the next line.
- R10: When clamp is high the tracking enable is 111 with configuration 10. With the other configurations it is the one-hot code of the selected input (bit n for colour n). When clamp is low it is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_clk_i | input | 1 | Converter clock, sampled |
| line_sync_i | input | 1 | Line-start pulse; high holds the pixel pointer at red |
| clamp_i | input | 1 | Clamp pulse |
| cfg_mode_i | input | 2 | Rotation configuration (00, 01, 10, 11) |
| red_cmd_i | input | 1 | Reset-to-red command pulse |
| gain_tab_i | input | 18 | Packed gains, colour n at bits [6n+5:6n] |
| offs_tab_i | input | 24 | Packed offsets, colour n at bits [8n+7:8n] |
| in_sel_o | output | 2 | Selected input: 0 red, 1 green, 2 blue |
| gain_o | output | 6 | Selected gain |
| offs_o | output | 8 | Selected offset |
| sample_all_o | output | 1 | Simultaneous three-colour sample strobe |
| track_o | output | 3 | Per-colour clamp/track enables |

## Verification
The hardest state to reach is the line rotation after a reset-to-red command. The first line start that follows must stay red, and only later line starts advance and wrap. The stimulus walks the line mode through a full red, green, blue and red wrap. It then issues the command in the middle of a green line and checks two line starts: the first must stay red and the second must move to green. It also rewrites the red table entry in the middle of a line to show that the outputs wait for the next line start.

// File: rtl/chroma_pkg.sv
`timescale 1ns/1ps
package chroma_pkg;
    localparam int NUM_CH = 3;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef logic [CH_W-1:0] ch_t;

    typedef enum logic [1:0] {
        CFG_RED_ONLY    = 2'b00,
        CFG_GAIN_PIX    = 2'b01,
        CFG_TRIPLE_PIX  = 2'b10,
        CFG_TRIPLE_LINE = 2'b11
    } cfg_e;

    function automatic ch_t ch_next(ch_t c);
        return (c == ch_t'(NUM_CH - 1)) ? '0 : c + 1'b1;
    endfunction
endpackage

// File: rtl/chroma_edge.sv
`timescale 1ns/1ps
module chroma_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_i,
    input  logic sync_i,
    output logic conv_fall_o,
    output logic sync_rise_o
);
    typedef struct packed {
        logic conv;
        logic sync;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.conv = conv_i;
        st_d.sync = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_fall_o = st_q.conv & ~conv_i;
    assign sync_rise_o = ~st_q.sync & sync_i;
endmodule

// File: rtl/chroma_ptr.sv
`timescale 1ns/1ps
module chroma_ptr
    import chroma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_e cfg_i,
    input  logic sync_i,
    input  logic conv_fall_i,
    input  logic sync_rise_i,
    input  logic red_cmd_i,
    output ch_t  pix_d_o,
    output ch_t  line_d_o,
    output logic px_evt_o,
    output logic ln_evt_o,
    output logic sample_o
);
    typedef struct packed {
        ch_t  pix;
        ch_t  line;
        logic started;
        logic first;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.pix     = '0;
            st_d.started = 1'b0;
        end else if (conv_fall_i) begin
            if (st_q.started) st_d.pix = ch_next(st_q.pix);
            else              st_d.started = 1'b1;
        end
        if (sync_rise_i && cfg_i == CFG_TRIPLE_LINE) begin
            if (st_q.first) st_d.first = 1'b0;
            else            st_d.line  = ch_next(st_q.line);
        end
        if (red_cmd_i) begin
            st_d.line  = '0;
            st_d.first = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pix: '0, line: '0, started: 1'b0, first: 1'b1};
        else        st_q <= st_d;
    end

    assign pix_d_o  = st_d.pix;
    assign line_d_o = st_d.line;
    assign px_evt_o = conv_fall_i & ~sync_i;
    assign ln_evt_o = sync_rise_i | red_cmd_i;
    assign sample_o = px_evt_o && (cfg_i == CFG_TRIPLE_PIX) && (st_d.pix == '0);

    assert_pix_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(st_q.pix) < NUM_CH) && (int'(st_q.line) < NUM_CH));

    assert_sync_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (st_q.pix == '0));

    assert_cmd_red_R8: assert property (@(posedge clk) disable iff (!rst_n)
        red_cmd_i |=> (st_q.line == '0));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_i || conv_fall_i || sync_rise_i || red_cmd_i)
        |=> ($stable(st_q.pix) && $stable(st_q.line)));
endmodule

// File: rtl/chroma_sel.sv
`timescale 1ns/1ps
module chroma_sel
    import chroma_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cfg_e                     cfg_i,
    input  ch_t                      pix_i,
    input  ch_t                      line_i,
    input  logic                     px_evt_i,
    input  logic                     ln_evt_i,
    input  logic                     sample_i,
    input  logic                     clamp_i,
    input  logic [NUM_CH*GAIN_W-1:0] gain_tab_i,
    input  logic [NUM_CH*OFFS_W-1:0] offs_tab_i,
    output ch_t                      in_sel_o,
    output logic [GAIN_W-1:0]        gain_o,
    output logic [OFFS_W-1:0]        offs_o,
    output logic                     sample_o,
    output logic [NUM_CH-1:0]        track_o
);
    typedef struct packed {
        ch_t               in_sel;
        logic [GAIN_W-1:0] gain;
        logic [OFFS_W-1:0] offs;
        logic              sample;
        logic [NUM_CH-1:0] track;
    } sel_st_t;

    sel_st_t st_d, st_q;

    logic [GAIN_W-1:0] gain_arr [NUM_CH];
    logic [OFFS_W-1:0] offs_arr [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slice
        assign gain_arr[c] = gain_tab_i[c*GAIN_W +: GAIN_W];
        assign offs_arr[c] = offs_tab_i[c*OFFS_W +: OFFS_W];
    end

    ch_t  in_n, gsel_n;
    logic load;

    always_comb begin
        case (cfg_i)
            CFG_GAIN_PIX:    begin in_n = '0;     gsel_n = pix_i;  end
            CFG_TRIPLE_PIX:  begin in_n = pix_i;  gsel_n = pix_i;  end
            CFG_TRIPLE_LINE: begin in_n = line_i; gsel_n = line_i; end
            default:         begin in_n = '0;     gsel_n = '0;     end
        endcase
        load = (cfg_i == CFG_TRIPLE_LINE) ? ln_evt_i : (px_evt_i | ln_evt_i);

        st_d        = st_q;
        st_d.in_sel = in_n;
        st_d.sample = sample_i;
        if (load) begin
            st_d.gain = gain_arr[gsel_n];
            st_d.offs = offs_arr[gsel_n];
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (!clamp_i)                     st_d.track[c] = 1'b0;
            else if (cfg_i == CFG_TRIPLE_PIX) st_d.track[c] = 1'b1;
            else                              st_d.track[c] = (in_n == ch_t'(c));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_sel_o = st_q.in_sel;
    assign gain_o   = st_q.gain;
    assign offs_o   = st_q.offs;
    assign sample_o = st_q.sample;
    assign track_o  = st_q.track;

    assert_red_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i == CFG_RED_ONLY) |=> (st_q.in_sel == '0));

    assert_sample_red_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sample |-> (st_q.in_sel == '0));

    assert_track_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_i |=> (st_q.track == '0));
endmodule

// File: rtl/chroma_rotator.sv
`timescale 1ns/1ps
module chroma_rotator
    import chroma_pkg::*;
#(
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     conv_clk_i,
    input  logic                     line_sync_i,
    input  logic                     clamp_i,
    input  logic [1:0]               cfg_mode_i,
    input  logic                     red_cmd_i,
    input  logic [NUM_CH*GAIN_W-1:0] gain_tab_i,
    input  logic [NUM_CH*OFFS_W-1:0] offs_tab_i,
    output logic [CH_W-1:0]          in_sel_o,
    output logic [GAIN_W-1:0]        gain_o,
    output logic [OFFS_W-1:0]        offs_o,
    output logic                     sample_all_o,
    output logic [NUM_CH-1:0]        track_o
);
    cfg_e cfg;
    logic conv_fall, sync_rise, px_evt, ln_evt, sample;
    ch_t  pix_d, line_d;

    assign cfg = cfg_e'(cfg_mode_i);

    chroma_edge i_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_i      (conv_clk_i),
        .sync_i      (line_sync_i),
        .conv_fall_o (conv_fall),
        .sync_rise_o (sync_rise)
    );

    chroma_ptr i_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .sync_i      (line_sync_i),
        .conv_fall_i (conv_fall),
        .sync_rise_i (sync_rise),
        .red_cmd_i   (red_cmd_i),
        .pix_d_o     (pix_d),
        .line_d_o    (line_d),
        .px_evt_o    (px_evt),
        .ln_evt_o    (ln_evt),
        .sample_o    (sample)
    );

    chroma_sel #(.GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) i_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (cfg),
        .pix_i      (pix_d),
        .line_i     (line_d),
        .px_evt_i   (px_evt),
        .ln_evt_i   (ln_evt),
        .sample_i   (sample),
        .clamp_i    (clamp_i),
        .gain_tab_i (gain_tab_i),
        .offs_tab_i (offs_tab_i),
        .in_sel_o   (in_sel_o),
        .gain_o     (gain_o),
        .offs_o     (offs_o),
        .sample_o   (sample_all_o),
        .track_o    (track_o)
    );

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!px_evt && !ln_evt) |=> ($stable(gain_o) && $stable(offs_o)));
endmodule

// File: tb/test_chroma_rotator.sv
`timescale 1ns/1ps
module test_chroma_rotator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv = 1'b1;
    logic        sync = 1'b0;
    logic        clamp = 1'b0;
    logic        cmd = 1'b0;
    logic [1:0]  cfg = 2'b00;
    logic [17:0] gtab = {6'd42, 6'd21, 6'd5};
    logic [23:0] otab = {8'h33, 8'h22, 8'h11};
    logic [1:0]  in_sel;
    logic [5:0]  gain;
    logic [7:0]  offs;
    logic        sample;
    logic [2:0]  track;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    chroma_rotator i_chroma_rotator (
        .clk(clk), .rst_n(rst_n), .conv_clk_i(conv), .line_sync_i(sync),
        .clamp_i(clamp), .cfg_mode_i(cfg), .red_cmd_i(cmd),
        .gain_tab_i(gtab), .offs_tab_i(otab), .in_sel_o(in_sel),
        .gain_o(gain), .offs_o(offs), .sample_all_o(sample), .track_o(track)
    );

    always #2.5 clk = ~clk;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_gain(int c);
        return int'(gtab[c*6 +: 6]);
    endfunction

    function automatic int exp_offs(int c);
        return int'(otab[c*8 +: 8]);
    endfunction

    task automatic check_colour(string req, int in_exp, int g_exp);
        check(req, "in_sel", int'(in_sel), in_exp);
        check(req, "gain", int'(gain), exp_gain(g_exp));
        check(req, "offs", int'(offs), exp_offs(g_exp));
    endtask

    task automatic pixel();
        @(negedge clk) conv = 1'b1;
        @(negedge clk) conv = 1'b0;
        @(negedge clk);
    endtask

    task automatic line_start();
        @(negedge clk) sync = 1'b1;
        @(negedge clk);
        @(negedge clk) sync = 1'b0;
        @(negedge clk);
    endtask

    task automatic red_command();
        @(negedge clk) cmd = 1'b1;
        @(negedge clk) cmd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "in_sel", int'(in_sel), 0);
        check("R1", "gain", int'(gain), 0);
        check("R1", "offs", int'(offs), 0);
        check("R1", "sample", int'(sample), 0);
        check("R1", "track", int'(track), 0);
    endtask

    task automatic t_red_only();
        cfg = 2'b00;
        line_start();
        check_colour("R2", 0, 0);
        for (int k = 0; k < 4; k++) begin
            pixel();
            check_colour("R2", 0, 0);
        end
    endtask

    task automatic t_gain_rotate();
        cfg = 2'b01;
        line_start();
        check_colour("R3", 0, 0);
        for (int k = 0; k < 5; k++) begin
            pixel();
            check_colour("R3", 0, k % 3);
        end
    endtask

    task automatic t_triple_pixel();
        cfg = 2'b10;
        line_start();
        for (int k = 0; k < 6; k++) begin
            pixel();
            check_colour("R4", k % 3, k % 3);
            check("R6", "sample strobe", int'(sample), (k % 3 == 0) ? 1 : 0);
            @(negedge clk);
            check("R6", "strobe width", int'(sample), 0);
        end
        // stop at green, then line pulse mid-rotation
        pixel();
        pixel();
        check("R4", "in_sel before sync", int'(in_sel), 1);
        @(negedge clk) sync = 1'b1;
        @(negedge clk);
        check("R5", "in_sel during sync", int'(in_sel), 0);
        pixel();
        check("R5", "in_sel fall under sync", int'(in_sel), 0);
        @(negedge clk) sync = 1'b0;
        @(negedge clk);
        pixel();
        check_colour("R5", 0, 0);
        pixel();
        check_colour("R5", 1, 1);
        @(negedge clk) clamp = 1'b1;
        @(negedge clk);
        check("R10", "track triple", int'(track), 7);
        @(negedge clk) clamp = 1'b0;
        @(negedge clk);
        check("R10", "track off", int'(track), 0);
    endtask

    task automatic t_line_rotate();
        cfg = 2'b11;
        red_command();
        line_start();
        check_colour("R7", 0, 0);
        pixel();
        pixel();
        check_colour("R7", 0, 0);
        @(negedge clk) gtab[5:0] = 6'd7;
        pixel();
        check("R9", "gain held mid-line", int'(gain), 5);
        line_start();
        check_colour("R7", 1, 1);
        line_start();
        check_colour("R7", 2, 2);
        line_start();
        check_colour("R7", 0, 0);
        check("R9", "new gain at line start", int'(gain), 7);
        line_start();
        check_colour("R7", 1, 1);
        @(negedge clk) clamp = 1'b1;
        @(negedge clk);
        check("R10", "track green line", int'(track), 2);
        @(negedge clk) clamp = 1'b0;
        red_command();
        check_colour("R8", 0, 0);
        line_start();
        check_colour("R7", 0, 0);
        line_start();
        check_colour("R7", 1, 1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_red_only();
        t_gain_rotate();
        t_triple_pixel();
        t_line_rotate();
        done = 1;
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            finish_run();
        end
    end
endmodule